// File: doc/BRIEF.md
# Longitudinal Bang-Bang Bunch Damper

This block receives one phase sample per bunch slot, slot after slot, turn after turn. For every slot it keeps the samples from the seven previous turns in an on-chip history store that is addressed by slot index. Each new sample is combined with that slot's history through an eight-tap FIR filter with programmable signed coefficients. With coefficients that sum to zero, the filter gives an estimate of how fast the bunch phase is drifting.

The estimate is compared with an upper and a lower programmable threshold. Above the upper threshold the bunch gets a fixed positive kick. Below the lower threshold it gets a fixed negative kick. Between the two thresholds, or at either one exactly, no kick is issued. The kick value drives a damper DAC directly.

An optional intensity gate blocks the kick for buckets whose intensity falls below a programmable minimum. After reset no kick is issued until the filter window holds real samples for every slot. The slot position is tracked inside the block: the first accepted sample after reset is slot 0, and the index wraps after the last slot of a turn.

Top module: `bbdamp_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0, `out_kick` is 00 and `out_dac` is 0.
- R2: Each cycle with `in_valid` high yields `out_valid` high on the next cycle, with `out_slot` equal to the slot index of that sample. The first sample after reset is slot 0, the index rises by one per sample and wraps from NUM_SLOTS-1 to 0. A cycle without `in_valid` yields `out_valid` 0, `out_kick` 00 and `out_dac` 0 on the next cycle.
- R3: `out_deriv` equals the sum over k = 0..7 of coefficient k times the phase of the same slot from k turns earlier, where k = 0 is the current sample. Coefficient k is the two's-complement field `cfg_coef[k*CW +: CW]`.
- R4: When kicks are enabled and `out_deriv` > `cfg_thr_hi` (signed), `out_kick` is 01 and `out_dac` is +KICK_AMP.
- R5: When kicks are enabled and `out_deriv` < `cfg_thr_lo` (signed), `out_kick` is 11 and `out_dac` is -KICK_AMP. The code 10 never appears.
- R6: When `cfg_thr_lo` <= `out_deriv` <= `cfg_thr_hi`, `out_kick` is 00 and `out_dac` is 0. Equality with either threshold gives no kick.
- R7: For samples in turns 0 to 6 after reset (turn 0 is the first NUM_SLOTS samples), `out_kick` is 00 whatever the phase values. Kicks are enabled from turn 7 onward.
- R8: With `cfg_gate_en` = 1, a sample whose `in_intensity` is below `cfg_int_min` (unsigned) gives `out_kick` 00. With `cfg_gate_en` = 0, `in_intensity` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A bunch phase sample is present |
| in_phase | input | PW | Signed bunch phase sample |
| in_intensity | input | IW | Unsigned bunch intensity |
| cfg_coef | input | TAPS*CW | Signed filter coefficients; tap k at bits k*CW |
| cfg_thr_hi | input | SUMW | Signed upper threshold |
| cfg_thr_lo | input | SUMW | Signed lower threshold |
| cfg_gate_en | input | 1 | Enable the intensity gate |
| cfg_int_min | input | IW | Minimum intensity that allows a kick |
| out_valid | output | 1 | A kick decision is present |
| out_slot | output | SLW | Slot index of the decision |
| out_kick | output | 2 | 00 none, 01 positive, 11 negative |
| out_dac | output | DW | Signed kick value for the DAC |
| out_deriv | output | SUMW | Filter output for the slot |

## Verification
A wrong slot pointer or turn counter shows up at the ports on the very next decision. It appears as an out-of-sequence `out_slot`, or as a kick issued during the seven warm-up turns or withheld after them. A corrupted history entry does not show up at once. It appears in `out_deriv` for that slot one turn later, and it stays visible for up to seven turns while the bad sample moves through the taps. For that reason the filter output is compared on every decision once the window is full, not only the kick codes. Threshold ties and gate toggles are driven on purpose, because an error in the comparison only shows at those edges.

// File: rtl/bbdamp_pkg.sv
package bbdamp_pkg;
    typedef enum logic [1:0] {
        KICK_NONE = 2'b00,
        KICK_POS  = 2'b01,
        KICK_NEG  = 2'b11
    } kick_e;
endpackage

// File: rtl/bbdamp_hist.sv
// Per-slot history store: holds the TAPS-1 previous-turn samples of each slot.
// Entry layout: sample from k turns ago sits at [(k-1)*PW +: PW].
module bbdamp_hist #(
    parameter int NUM_SLOTS = 588,
    parameter int TAPS      = 8,
    parameter int PW        = 14,
    localparam int SLW      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int EW       = (TAPS - 1) * PW
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [SLW-1:0]       addr,
    input  logic signed [PW-1:0] cur_phase,
    output logic [EW-1:0]        rd_entry
);
    logic [EW-1:0] mem_q [NUM_SLOTS];
    logic [EW-1:0] entry_d;

    assign rd_entry = mem_q[addr];

    generate
        if (TAPS > 2) begin : g_shift
            assign entry_d = {rd_entry[(TAPS-2)*PW-1:0], cur_phase};
        end else begin : g_single
            assign entry_d = cur_phase;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[addr] <= entry_d;
        end
    end

    always_comb begin
        assert_addr_in_range_R2: assert (!wr_en || (32'(addr) < NUM_SLOTS));
    end
endmodule

// File: rtl/bbdamp_fir.sv
// Eight-tap (TAPS) multi-turn FIR: tap 0 is the current sample.
module bbdamp_fir #(
    parameter int TAPS = 8,
    parameter int PW   = 14,
    parameter int CW   = 10,
    localparam int SUMW = PW + CW + $clog2(TAPS),
    localparam int EW   = (TAPS - 1) * PW
) (
    input  logic signed [PW-1:0]   cur_phase,
    input  logic [EW-1:0]          hist,
    input  logic [TAPS*CW-1:0]     coef,
    output logic signed [SUMW-1:0] deriv
);
    logic signed [PW-1:0]    tap   [TAPS];
    logic signed [PW+CW-1:0] prod  [TAPS];

    assign tap[0] = cur_phase;
    generate
        for (genvar k = 1; k < TAPS; k++) begin : g_tap
            assign tap[k] = hist[(k-1)*PW +: PW];
        end
        for (genvar k = 0; k < TAPS; k++) begin : g_mul
            assign prod[k] = tap[k] * $signed(coef[k*CW +: CW]);
        end
    endgenerate

    always_comb begin
        deriv = '0;
        for (int k = 0; k < TAPS; k++) begin
            deriv = deriv + SUMW'(prod[k]);
        end
    end
endmodule

// File: rtl/bbdamp_slicer.sv
// Three-level quantiser with warm-up and intensity qualification.
module bbdamp_slicer
    import bbdamp_pkg::*;
#(
    parameter int SUMW     = 27,
    parameter int IW       = 12,
    parameter int DW       = 12,
    parameter int KICK_AMP = 1500
) (
    input  logic signed [SUMW-1:0] deriv,
    input  logic signed [SUMW-1:0] thr_hi,
    input  logic signed [SUMW-1:0] thr_lo,
    input  logic                   armed,
    input  logic                   gate_en,
    input  logic [IW-1:0]          intensity,
    input  logic [IW-1:0]          int_min,
    output kick_e                  kick,
    output logic signed [DW-1:0]   dac
);
    logic allow;

    assign allow = armed && (!gate_en || (intensity >= int_min));

    always_comb begin
        kick = KICK_NONE;
        dac  = '0;
        if (allow) begin
            if (deriv > thr_hi) begin
                kick = KICK_POS;
                dac  = DW'(KICK_AMP);
            end else if (deriv < thr_lo) begin
                kick = KICK_NEG;
                dac  = -DW'(KICK_AMP);
            end
        end
    end
endmodule

// File: rtl/bbdamp_top.sv
module bbdamp_top
    import bbdamp_pkg::*;
#(
    parameter int NUM_SLOTS = 588,
    parameter int TAPS      = 8,
    parameter int PW        = 14,
    parameter int CW        = 10,
    parameter int IW        = 12,
    parameter int DW        = 12,
    parameter int KICK_AMP  = 1500,
    localparam int SLW      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int TW       = $clog2(TAPS),
    localparam int SUMW     = PW + CW + $clog2(TAPS),
    localparam int EW       = (TAPS - 1) * PW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [PW-1:0]   in_phase,
    input  logic [IW-1:0]          in_intensity,
    input  logic [TAPS*CW-1:0]     cfg_coef,
    input  logic signed [SUMW-1:0] cfg_thr_hi,
    input  logic signed [SUMW-1:0] cfg_thr_lo,
    input  logic                   cfg_gate_en,
    input  logic [IW-1:0]          cfg_int_min,
    output logic                   out_valid,
    output logic [SLW-1:0]         out_slot,
    output logic [1:0]             out_kick,
    output logic signed [DW-1:0]   out_dac,
    output logic signed [SUMW-1:0] out_deriv
);
    localparam logic [SLW-1:0] LAST_SLOT = SLW'(NUM_SLOTS - 1);
    localparam logic [TW-1:0]  FULL_TURN = TW'(TAPS - 1);

    typedef struct packed {
        logic                   valid;
        logic [SLW-1:0]         ptr;
        logic [SLW-1:0]         slot;
        logic [TW-1:0]          turn;
        kick_e                  kick;
        logic signed [DW-1:0]   dac;
        logic signed [SUMW-1:0] deriv;
    } state_t;

    state_t st_d, st_q;

    logic [EW-1:0]          hist_entry;
    logic signed [SUMW-1:0] fir_sum;
    kick_e                  sl_kick;
    logic signed [DW-1:0]   sl_dac;
    logic                   armed;

    assign armed = (st_q.turn == FULL_TURN);

    bbdamp_hist #(.NUM_SLOTS(NUM_SLOTS), .TAPS(TAPS), .PW(PW)) u_hist (
        .clk       (clk),
        .wr_en     (in_valid),
        .addr      (st_q.ptr),
        .cur_phase (in_phase),
        .rd_entry  (hist_entry)
    );

    bbdamp_fir #(.TAPS(TAPS), .PW(PW), .CW(CW)) u_fir (
        .cur_phase (in_phase),
        .hist      (hist_entry),
        .coef      (cfg_coef),
        .deriv     (fir_sum)
    );

    bbdamp_slicer #(.SUMW(SUMW), .IW(IW), .DW(DW), .KICK_AMP(KICK_AMP)) u_slicer (
        .deriv     (fir_sum),
        .thr_hi    (cfg_thr_hi),
        .thr_lo    (cfg_thr_lo),
        .armed     (armed),
        .gate_en   (cfg_gate_en),
        .intensity (in_intensity),
        .int_min   (cfg_int_min),
        .kick      (sl_kick),
        .dac       (sl_dac)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.kick  = KICK_NONE;
        st_d.dac   = '0;
        if (in_valid) begin
            st_d.slot  = st_q.ptr;
            st_d.kick  = sl_kick;
            st_d.dac   = sl_dac;
            st_d.deriv = fir_sum;
            if (st_q.ptr == LAST_SLOT) begin
                st_d.ptr = '0;
                if (!armed) begin
                    st_d.turn = st_q.turn + 1'b1;
                end
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{valid: 1'b0, ptr: '0, slot: '0, turn: '0,
                      kick: KICK_NONE, dac: '0, deriv: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_slot  = st_q.slot;
    assign out_kick  = st_q.kick;
    assign out_dac   = st_q.dac;
    assign out_deriv = st_q.deriv;

    assert_follow_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && out_kick == 2'b00 && out_dac == '0));
    assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && st_q.ptr == LAST_SLOT) |=> (out_slot == LAST_SLOT && st_q.ptr == '0));
    assert_no_bad_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_kick != 2'b10);
    assert_dac_matches_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_kick == 2'b01) |-> (out_dac == DW'(KICK_AMP)));
    assert_warmup_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && st_q.turn != FULL_TURN) |=> (out_kick == 2'b00));
endmodule

// File: tb/bbdamp_top_tb.sv
module bbdamp_top_tb;
    localparam int NS   = 5;
    localparam int TAPS = 8;
    localparam int PW   = 14;
    localparam int CW   = 10;
    localparam int IW   = 12;
    localparam int DW   = 12;
    localparam int AMP  = 1500;
    localparam int SLW  = $clog2(NS);
    localparam int SUMW = PW + CW + $clog2(TAPS);

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic signed [PW-1:0]   in_phase = '0;
    logic [IW-1:0]          in_intensity = '0;
    logic [TAPS*CW-1:0]     cfg_coef = '0;
    logic signed [SUMW-1:0] cfg_thr_hi = '0;
    logic signed [SUMW-1:0] cfg_thr_lo = '0;
    logic                   cfg_gate_en = 1'b0;
    logic [IW-1:0]          cfg_int_min = '0;
    logic                   out_valid;
    logic [SLW-1:0]         out_slot;
    logic [1:0]             out_kick;
    logic signed [DW-1:0]   out_dac;
    logic signed [SUMW-1:0] out_deriv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int coef_m [TAPS];
    int hist_m [NS][TAPS];
    int ptr_m  = 0;
    int turn_m = 0;
    int thr_hi_m = 0;
    int thr_lo_m = 0;
    int gate_m = 0;
    int imin_m = 0;

    always #10 clk = ~clk;

    bbdamp_top #(.NUM_SLOTS(NS), .TAPS(TAPS), .PW(PW), .CW(CW), .IW(IW),
                 .DW(DW), .KICK_AMP(AMP)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_phase(in_phase),
        .in_intensity(in_intensity), .cfg_coef(cfg_coef), .cfg_thr_hi(cfg_thr_hi),
        .cfg_thr_lo(cfg_thr_lo), .cfg_gate_en(cfg_gate_en), .cfg_int_min(cfg_int_min),
        .out_valid(out_valid), .out_slot(out_slot), .out_kick(out_kick),
        .out_dac(out_dac), .out_deriv(out_deriv)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int hi, input int lo, input int gate, input int imin);
        thr_hi_m = hi; thr_lo_m = lo; gate_m = gate; imin_m = imin;
        cfg_thr_hi  = SUMW'(hi);
        cfg_thr_lo  = SUMW'(lo);
        cfg_gate_en = gate[0];
        cfg_int_min = IW'(imin);
    endtask

    task automatic set_coefs();
        for (int k = 0; k < TAPS; k++) cfg_coef[k*CW +: CW] = CW'(coef_m[k]);
    endtask

    function automatic int fir_model(input int cur, input int s);
        int acc = coef_m[0] * cur;
        for (int k = 1; k < TAPS; k++) acc += coef_m[k] * hist_m[s][k-1];
        return acc;
    endfunction

    task automatic model_reset();
        ptr_m = 0; turn_m = 0;
        for (int s = 0; s < NS; s++)
            for (int k = 0; k < TAPS; k++) hist_m[s][k] = 0;
    endtask

    // Drive one sample at a falling edge, check the decision one edge later.
    task automatic bunch(input int ph, input int inten);
        int s = ptr_m;
        int d = fir_model(ph, s);
        bit armed = (turn_m == TAPS - 1);
        bit gate_ok = (gate_m == 0) || (inten >= imin_m);
        int ek = 0;
        int ed = 0;
        string tag = "R6 dead band";
        if (!armed) tag = "R7 warm-up";
        else if (!gate_ok) tag = "R8 intensity gate";
        else if (d > thr_hi_m) begin ek = 1; ed = AMP; tag = "R4 positive kick"; end
        else if (d < thr_lo_m) begin ek = 3; ed = -AMP; tag = "R5 negative kick"; end
        in_valid = 1'b1;
        in_phase = PW'(ph);
        in_intensity = IW'(inten);
        for (int k = TAPS - 2; k > 0; k--) hist_m[s][k] = hist_m[s][k-1];
        hist_m[s][0] = ph;
        if (ptr_m == NS - 1) begin
            ptr_m = 0;
            if (turn_m < TAPS - 1) turn_m++;
        end else ptr_m++;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 valid", int'(out_valid), 1);
        chk("R2 slot", int'(out_slot), s);
        chk(tag, int'(out_kick), ek);
        chk(tag, int'(out_dac), ed);
        if (armed) chk("R3 filter", int'(out_deriv), d);
    endtask

    task automatic idle();
        in_valid = 1'b0;
        in_intensity = IW'($urandom_range(4095));
        @(negedge clk);
        chk("R2 idle valid", int'(out_valid), 0);
        chk("R2 idle kick", int'(out_kick), 0);
        chk("R2 idle dac", int'(out_dac), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", int'(out_valid), 0);
        chk("R1 reset kick", int'(out_kick), 0);
        chk("R1 reset dac", int'(out_dac), 0);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        chk("R1 after reset valid", int'(out_valid), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int slope [NS] = '{3, -3, 2, 0, 1};
        int t = 0;
        void'($urandom(32'd7135));
        coef_m = '{7, 5, 3, 1, -1, -3, -5, -7};
        set_coefs();
        set_cfg(200, -200, 0, 0);
        @(negedge clk);
        do_reset();

        // Phase ramps: derivative = 84*slope; first 7 turns must stay silent (R7).
        for (int tn = 0; tn < 9; tn++) begin
            for (int s = 0; s < NS; s++) bunch(1000 * s + slope[s] * t, 100);
            t++;
            idle();
        end

        // Threshold ties give no kick (R6).
        set_cfg(252, -252, 0, 0);
        for (int s = 0; s < NS; s++) bunch(1000 * s + slope[s] * t, 100);
        t++;

        // Intensity gate: weak buckets silenced, strong ones kicked (R8).
        set_cfg(200, -200, 1, 500);
        for (int s = 0; s < NS; s++) bunch(1000 * s + slope[s] * t, 499);
        t++;
        for (int s = 0; s < NS; s++) bunch(1000 * s + slope[s] * t, 500);
        t++;
        set_cfg(200, -200, 0, 500);
        for (int s = 0; s < NS; s++) bunch(1000 * s + slope[s] * t, 3);
        t++;

        // Random coefficients summing to zero, random phases and gating.
        begin
            int sum = 0;
            for (int k = 0; k < TAPS - 1; k++) begin
                coef_m[k] = $urandom_range(120) - 60;
                sum += coef_m[k];
            end
            coef_m[TAPS-1] = -sum;
            set_coefs();
        end
        for (int i = 0; i < 400; i++) begin
            if (i % 25 == 0)
                set_cfg($urandom_range(40000), -$urandom_range(40000),
                        $urandom_range(1), $urandom_range(4095));
            bunch($urandom_range(8000) - 4000, $urandom_range(4095));
            if ($urandom_range(3) == 0) idle();
        end

        // Reset mid-run: warm-up restarts (R7).
        coef_m = '{7, 5, 3, 1, -1, -3, -5, -7};
        set_coefs();
        set_cfg(10, -10, 0, 0);
        do_reset();
        for (int tn = 0; tn < 8; tn++)
            for (int s = 0; s < NS; s++) bunch(50 * s * tn - 2000, 100);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule